// File: doc/BRIEF.md
# Successive-Approximation Converter Control

This block is the digital half of a 7-bit successive-approximation converter. Software sees two byte-wide registers: a control register and a result register. The control register holds a start bit, a comparator source select and four mode bits. The block decodes the mode bits into internal conversions (three variants), external operation, D/A operation or a reserved setting. Only the three internal modes run a conversion.

A conversion can be requested by a write of 1 to the start bit or by a request line from an external diversity controller. It resolves one bit per clock, most significant bit first, against a single comparator bit, which stands in for the analog compare. While it runs, the result register shows a busy flag in bit 7 and the live trial code in bits 6:0. That code is also driven on the 7-bit pin bus. A one-clock done pulse marks the end of each conversion.

When the D/A mode bit is set, a write to the result register puts its low seven bits straight onto the pin bus.

Top module: `sar_conv_top`

## Requirements
- R1: After reset, both registers read 0x00, and `convActive`, `convDone`, `srcSel` and `sarOut` are 0.
- R2: The mode is the tuple (D/A=ctrl bit 2, ext=bit 3, sar=bit 4, alt=bit 5). Conversions run only in 0000 (internal A), 0010 (internal B) and 0011 (internal C). A start or request in any other code (010x external, 1x1x D/A, 0001/011x/1x0x reserved) leaves `convActive` at 0.
- R3: `srcSel` equals ctrl bit 1 in the internal modes and is 0 in all other modes.
- R4: A write to the control register (address 0) stores bits 5:0, which read back with bits 7:6 as 0. Every such write with bit 0 = 1 in an internal mode starts a conversion, even when bit 0 already reads 1.
- R5: A start write or a diversity request arriving while a conversion runs is ignored. The running conversion keeps its length and its result.
- R6: `convActive` rises on the clock edge that accepts a start and stays high for exactly 7 cycles. Result register (address 1) bit 7 equals `convActive`.
- R7: In the first active cycle the trial code is 0x40. Each later edge keeps the current trial bit if `cmpIn` is 1, clears it if `cmpIn` is 0, and sets the next lower bit. For an input level v in 0..127, compared as v >= code, the final code equals v.
- R8: `convDone` is high for exactly the one cycle in which `convActive` has just fallen. At that point the final code is readable.
- R9: A one-cycle pulse on `divReq` in an internal mode starts a conversion exactly like a software start.
- R10: With ctrl bit 2 = 1, a write to address 1 drives write-data bits 6:0 onto `sarOut` from the next cycle. With ctrl bit 2 = 0, such a write leaves `sarOut` unchanged.
- R11: Result register bits 6:0 always equal the current `sarOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 control, 1 result |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read target: 0 control, 1 result |
| rdData | output | 8 | Read data of the selected register |
| divReq | input | 1 | Conversion request from the diversity controller |
| cmpIn | input | 1 | Comparator result: 1 when input is at or above the trial level |
| srcSel | output | 1 | Analog source select: 0 input 1, 1 input 2 |
| sarOut | output | 7 | Live approximation / D/A code pins |
| convActive | output | 1 | Conversion in progress |
| convDone | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong step index or a misplaced trial bit shows up on `sarOut` within one cycle of the start, because the bench comparator follows the pins directly. After seven edges the final code then differs from the bench's arithmetic level. A sequencer that restarts on a second request, or that counts wrongly, changes the length of `convActive` and the timing of `convDone` within the same conversion. A mode decode error shows on the very next cycle, through `convActive` and `srcSel`, because the bench sweeps every code of the mode field.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  // control register field positions
  localparam int CB_START = 0;
  localparam int CB_SRC   = 1;
  localparam int CB_DA    = 2;
  localparam int CB_EXT   = 3;
  localparam int CB_SAR   = 4;
  localparam int CB_ALT   = 5;
  localparam int CTRL_W   = 6;

  typedef enum logic [2:0] {
    MODE_INT_A,
    MODE_INT_B,
    MODE_INT_C,
    MODE_EXT,
    MODE_DA,
    MODE_RSVD
  } conv_mode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;     // load first trial code
    logic resolve;  // decide current bit, set next
    logic daLoad;   // direct pin write
  } ctl_strobe_t;

  function automatic logic [3:0] modeBits(input logic [CTRL_W-1:0] c);
    return {c[CB_DA], c[CB_EXT], c[CB_SAR], c[CB_ALT]};
  endfunction

  function automatic conv_mode_e decodeMode(input logic [3:0] m);
    conv_mode_e r;
    casez (m)
      4'b0000: r = MODE_INT_A;
      4'b0010: r = MODE_INT_B;
      4'b0011: r = MODE_INT_C;
      4'b010?: r = MODE_EXT;
      4'b1?1?: r = MODE_DA;
      default: r = MODE_RSVD;
    endcase
    return r;
  endfunction

  function automatic logic isInternal(input conv_mode_e m);
    return (m == MODE_INT_A) || (m == MODE_INT_B) || (m == MODE_INT_C);
  endfunction

endpackage

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int BITS = 7,
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtrl,
  input  logic              wrResult,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              divReq,
  output logic [CTRL_W-1:0] ctrlQ,
  output ctl_strobe_t       strobe,
  output logic [IDXW-1:0]   stepIdx,
  output logic              convActive,
  output logic              convDone,
  output logic              srcSel
);

  conv_mode_e curMode;
  conv_mode_e newMode;
  logic       swStart;
  logic       hwStart;
  logic       accept;
  logic       lastStep;

  assign curMode  = decodeMode(modeBits(ctrlQ));
  assign newMode  = decodeMode(modeBits(ctrlIn));
  assign swStart  = wrCtrl && ctrlIn[CB_START] && isInternal(newMode);
  assign hwStart  = divReq && isInternal(curMode);
  assign accept   = !convActive && (swStart || hwStart);
  assign lastStep = (stepIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrCtrl) begin
      ctrlQ <= ctrlIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convActive <= 1'b0;
      stepIdx    <= '0;
      convDone   <= 1'b0;
    end else begin
      convDone <= convActive && lastStep;
      if (accept) begin
        convActive <= 1'b1;
        stepIdx    <= IDXW'(BITS - 1);
      end else if (convActive) begin
        if (lastStep) begin
          convActive <= 1'b0;
        end else begin
          stepIdx <= stepIdx - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.init    = accept;
    strobe.resolve = convActive;
    strobe.daLoad  = wrResult && ctrlQ[CB_DA];
  end

  assign srcSel = ctrlQ[CB_SRC] && isInternal(curMode);

endmodule

// File: rtl/sar_conv_dp.sv
module sar_conv_dp
  import sar_conv_pkg::*;
#(
  parameter int BITS = 7,
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_strobe_t     strobe,
  input  logic [IDXW-1:0] stepIdx,
  input  logic            cmpIn,
  input  logic [BITS-1:0] daValue,
  output logic [BITS-1:0] sarQ
);

  logic [BITS-1:0] nextSar;
  logic [BITS-1:0] stepSar;

  // per-bit resolve: keep/clear the bit under test, raise the one below
  for (genvar i = 0; i < BITS; i++) begin : g_bit
    always_comb begin
      if (i == int'(stepIdx)) begin
        stepSar[i] = cmpIn;
      end else if (i + 1 == int'(stepIdx)) begin
        stepSar[i] = 1'b1;
      end else begin
        stepSar[i] = sarQ[i];
      end
    end
  end

  always_comb begin
    nextSar = sarQ;
    if (strobe.init) begin
      nextSar = '0;
      nextSar[BITS-1] = 1'b1;
    end else if (strobe.resolve) begin
      nextSar = stepSar;
    end else if (strobe.daLoad) begin
      nextSar = daValue;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ <= '0;
    end else begin
      sarQ <= nextSar;
    end
  end

endmodule

// File: rtl/sar_conv_top.sv
module sar_conv_top
  import sar_conv_pkg::*;
#(
  parameter int BITS = 7,
  parameter int DW   = 8,
  localparam int IDXW = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrAddr,
  input  logic [DW-1:0]   wrData,
  input  logic            rdAddr,
  output logic [DW-1:0]   rdData,
  input  logic            divReq,
  input  logic            cmpIn,
  output logic            srcSel,
  output logic [BITS-1:0] sarOut,
  output logic            convActive,
  output logic            convDone
);

  logic [CTRL_W-1:0] ctrlQ;
  ctl_strobe_t       strobe;
  logic [IDXW-1:0]   stepIdx;
  logic              wrCtrl;
  logic              wrResult;
  logic              unusedWrBits;

  assign wrCtrl       = wrEn && !wrAddr;
  assign wrResult     = wrEn && wrAddr;
  assign unusedWrBits = ^wrData;

  sar_conv_ctrl #(.BITS(BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrCtrl     (wrCtrl),
    .wrResult   (wrResult),
    .ctrlIn     (wrData[CTRL_W-1:0]),
    .divReq     (divReq),
    .ctrlQ      (ctrlQ),
    .strobe     (strobe),
    .stepIdx    (stepIdx),
    .convActive (convActive),
    .convDone   (convDone),
    .srcSel     (srcSel)
  );

  sar_conv_dp #(.BITS(BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .cmpIn   (cmpIn),
    .daValue (wrData[BITS-1:0]),
    .sarQ    (sarOut)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr) begin
      rdData[BITS-1:0] = sarOut;
      rdData[DW-1]     = convActive;
    end else begin
      rdData[CTRL_W-1:0] = ctrlQ;
    end
  end

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk
  import sar_conv_pkg::*;
#(
  parameter int BITS = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrAddr,
  input logic              divReq,
  input logic [CTRL_W-1:0] ctrlQ,
  input logic              srcSel,
  input logic [BITS-1:0]   sarOut,
  input logic              convActive,
  input logic              convDone
);

  localparam logic [BITS-1:0] FIRST_TRIAL = BITS'(1) << (BITS - 1);

  int unsigned runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= 0;
    end else begin
      runLen <= convActive ? runLen + 1 : 0;
    end
  end

  // R6: never more than BITS active cycles in one run
  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rstN)
    convActive |-> runLen < BITS);

  // R6: a run ends only after exactly BITS cycles
  a_r6_run_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convActive) |-> runLen == BITS);

  // R8: done pulse coincides with the fall of the busy flag
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convActive) |-> convDone);

  // R8: done never without a fall
  a_r8_done_only_fall: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (!convActive && $past(convActive)));

  // R7: first trial code is the top bit alone
  a_r7_first_trial: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convActive) |-> sarOut == FIRST_TRIAL);

  // R3: source select forced low outside internal modes
  a_r3_src_gated: assert property (@(posedge clk) disable iff (!rstN)
    !isInternal(decodeMode(modeBits(ctrlQ))) |-> !srcSel);

  // R10: result write with D/A bit clear leaves the pins alone
  a_r10_da_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr && !ctrlQ[CB_DA] && !convActive && !divReq) |=> $stable(sarOut));

endmodule

bind sar_conv_top sar_conv_chk #(.BITS(BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .divReq     (divReq),
  .ctrlQ      (ctrlQ),
  .srcSel     (srcSel),
  .sarOut     (sarOut),
  .convActive (convActive),
  .convDone   (convDone)
);

// File: tb/tb_sar_conv_top.sv
`timescale 1ns/100ps
module tb_sar_conv_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdAddr = 1'b1;
  logic [7:0] rdData;
  logic       divReq = 1'b0;
  logic       cmpIn;
  logic       srcSel;
  logic [6:0] sarOut;
  logic       convActive;
  logic       convDone;

  int ana1 = 0;
  int ana2 = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // comparator model: selected level at or above the trial code
  assign cmpIn = ((srcSel ? ana2 : ana1) >= int'(sarOut));

  sar_conv_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .divReq(divReq), .cmpIn(cmpIn),
    .srcSel(srcSel), .sarOut(sarOut), .convActive(convActive), .convDone(convDone)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic bit internalCode(input int c);
    bit da = c[0], ext = c[1], sr = c[2], alt = c[3];
    return !da && !ext && !(!sr && alt);
  endfunction

  // called at the first active negedge; follows the run to its end
  task automatic finishConv(input string tag, input int expCode, input int preCycles);
    int cnt = preCycles;
    while (convActive && cnt < 20) begin
      cnt++;
      @(negedge clk);
    end
    chk({tag, " R6 active length"}, cnt, 7);
    chk({tag, " R8 done pulse"}, convDone, 1);
    rdAddr = 1'b1; #0.1;
    chk({tag, " R7 R11 final code"}, rdData, expCode);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, convDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdAddr = 1'b0; #0.1;
    chk("R1 ctrl reset", rdData, 0);
    rdAddr = 1'b1; #0.1;
    chk("R1 result reset", rdData, 0);
    chk("R1 active reset", convActive, 0);
    chk("R1 done reset", convDone, 0);
    chk("R1 srcSel reset", srcSel, 0);
    chk("R1 pins reset", sarOut, 0);

    // R7 R3 R4 sweep: internal modes x sources x all levels
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 128; v++) begin
          logic [7:0] cw;
          cw = (m == 0) ? 8'h00 : (m == 1) ? 8'h10 : 8'h30;
          cw = cw | 8'(s << 1) | 8'h01;
          if (s == 1) begin ana2 = v; ana1 = 127 - v; end
          else begin ana1 = v; ana2 = 127 - v; end
          wr(1'b0, cw);
          chk("R4 restart with start bit already 1", convActive, 1);
          chk("R7 first trial", sarOut, 64);
          chk("R3 srcSel internal", srcSel, s);
          finishConv("sweep", v, 0);
        end
      end
    end

    // R4 readback
    wr(1'b0, 8'hF2);
    rdAddr = 1'b0; #0.1;
    chk("R4 ctrl readback", rdData, 8'h32);
    chk("R4 no start without bit0", convActive, 0);
    rdAddr = 1'b1;

    // R5 start write and request during a run are ignored
    ana1 = 100;
    wr(1'b0, 8'h01);
    begin
      int cnt = 0;
      while (convActive && cnt < 20) begin
        cnt++;
        if (cnt == 3) begin
          wrEn = 1'b1; wrAddr = 1'b0; wrData = 8'h01; divReq = 1'b1; ana1 = 5;
        end
        if (cnt == 4) begin
          wrEn = 1'b0; divReq = 1'b0; ana1 = 100;
        end
        @(negedge clk);
      end
      chk("R5 length unchanged", cnt, 7);
      chk("R5 done", convDone, 1);
      #0.1;
      chk("R5 result unchanged", rdData[6:0] == 100 ? 100 : int'(rdData[6:0]), 100);
      @(negedge clk);
    end

    // R2 R3 every mode code with start and source bit set
    ana1 = 40; ana2 = 40;
    for (int c = 0; c < 16; c++) begin
      wr(1'b0, 8'((c << 2) | 3));
      chk($sformatf("R2 mode %0d start", c), convActive, int'(internalCode(c)));
      chk($sformatf("R3 mode %0d srcSel", c), srcSel, int'(internalCode(c)));
      if (convActive) finishConv("R2 run", 40, 0);
    end

    // R9 diversity request
    ana1 = 77;
    wr(1'b0, 8'h00);
    @(negedge clk); divReq = 1'b1;
    @(negedge clk); divReq = 1'b0;
    chk("R9 request starts", convActive, 1);
    finishConv("R9 run", 77, 0);
    wr(1'b0, 8'h04);
    @(negedge clk); divReq = 1'b1;
    @(negedge clk); divReq = 1'b0;
    chk("R9 R2 request in reserved ignored", convActive, 0);

    // R10 D/A pass-through
    wr(1'b0, 8'h16);
    chk("R3 srcSel in D/A", srcSel, 0);
    wr(1'b1, 8'hD5);
    chk("R10 pins driven", sarOut, 8'h55);
    #0.1;
    chk("R11 readback of pins", rdData, 8'h55);
    @(negedge clk); divReq = 1'b1;
    @(negedge clk); divReq = 1'b0;
    chk("R2 request in D/A ignored", convActive, 0);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h2A);
    chk("R10 write ignored with D/A clear", sarOut, 8'h55);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule